// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block is the receive end of a three-wire serial programming port made of a serial clock, a serial data line and an active-low select. While the select is low, the block shifts one bit in on each rising serial-clock edge, most significant bit first. When the select returns high, it copies the received word into an active configuration register. It then decodes that register into the operating mode and the synthesizer and modulator settings used by the rest of the chip.

There are two word lengths. A short word carries 16 bits. A long word carries 25 bits: a fixed 9-bit prefix sits above a 16-bit body, and together they select receive with clock recovery. The number of serial clocks is never checked. Surplus leading bits simply fall off the top of the shift register.

The serial clock, data and select are brought into a faster system clock domain through synchroniser chains, and all edges are found there. The system clock must run at least four times faster than the serial clock.

Top module: `cfg3w_slave`

## Requirements
- R1: While the synchronised select is low, each rising serial-clock edge shifts one data bit in, MSB first. Serial-clock edges while the select is high change no output.
- R2: The active word, the length flag and the decoded outputs change only on a rise of the select. Each rise produces `upd` high for exactly one system clock.
- R3: The shift register is cleared when the select falls, so only the last bits clocked in are kept. If at least 25 bits arrive, the last 25 become the active word. Otherwise the last 16 bits are kept in bits 15:0, zero-filled if fewer than 16 bits arrived, and bits 24:16 are zero.
- R4: `long_word` is 1 exactly when at least 25 serial clocks arrived during the latched transfer. The bit count saturates at 25.
- R5: `mode` is a 3-bit code:
  - 0 (idle): from reset until the first latch.
  - 3 (receive with clock recovery): a long word whose bits 24:16 are 101000000 and whose bits 15:14 are 00.
  - 1 (transmit): any other word with bits 15:14 = 01 and bit 8 = 1.
  - 2 (receive): any other word with bits 15:14 = 01 and bit 8 = 0.
  - 4 (invalid): every other word.
- R6: `ramp_lvl` is bits 13:12 of the active word, a level index of 0 to 3. `dev_pct` equals 60 + 10 × bits 11:9, which gives 60 to 130.
- R7: `ref_hi` is bit 7, where 1 selects the 13.824 MHz reference and 0 selects 10.368 MHz. `main_div` equals 86 + bits 6:5. `swallow` is bits 4:0.
- R8: After reset the active word is all zeros, `mode` is idle, `long_word` and `upd` are 0, and the fields decode the zero word (`dev_pct` 60, `main_div` 86).
- R9: With two synchroniser stages, the new word and `upd` appear on the third system-clock edge after the select input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Active-low select, asynchronous |
| upd | output | 1 | One-cycle pulse when a word is latched |
| long_word | output | 1 | Latched word was 25 bits |
| act_word | output | 25 | Active configuration word |
| mode | output | 3 | Decoded mode code |
| ramp_lvl | output | 2 | Ramp level index |
| dev_pct | output | 8 | Deviation scaling in percent |
| ref_hi | output | 1 | Reference select |
| main_div | output | 7 | Main counter value |
| swallow | output | 5 | Swallow count |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, 16-bit and 25-bit word lengths, and the 9-bit prefix. The two-stage setting fixes the latch latency at three edges, so the model can predict every output on every cycle. The word lengths bring within reach the cases where bits are discarded (20 and 30 clocks), short and empty transfers, and a long word with the wrong prefix. A sweep covers every deviation and main-counter code.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int SHORT_W = 16;
  localparam int LONG_W  = 25;
  localparam int PFX_W   = LONG_W - SHORT_W;
  localparam int CNT_W   = $clog2(LONG_W + 1);
  localparam logic [PFX_W-1:0] CR_PREFIX = 9'b101000000;
  localparam int DEV_BASE = 60;
  localparam int DEV_STEP = 10;
  localparam int DIV_BASE = 86;

  typedef enum logic [2:0] {
    MODE_IDLE = 3'd0,
    MODE_TX   = 3'd1,
    MODE_RX   = 3'd2,
    MODE_RXCR = 3'd3,
    MODE_BAD  = 3'd4
  } mode_e;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_en_n,
  output logic sclk_rise,
  output logic en_fall,
  output logic en_rise,
  output logic en_low,
  output logic dat_s
);
  // each stage packs {clock, data, enable_n}
  logic [2:0] stg_q [STAGES];
  logic       ck_p_q, en_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= 3'b001;
      ck_p_q <= 1'b0;
      en_p_q <= 1'b1;
    end else begin
      stg_q[0] <= {ser_clk, ser_dat, ser_en_n};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      ck_p_q <= stg_q[STAGES-1][2];
      en_p_q <= stg_q[STAGES-1][0];
    end
  end

  always_comb begin
    dat_s     = stg_q[STAGES-1][1];
    en_low    = !stg_q[STAGES-1][0];
    sclk_rise = stg_q[STAGES-1][2] && !ck_p_q;
    en_fall   = !stg_q[STAGES-1][0] && en_p_q;
    en_rise   = stg_q[STAGES-1][0] && !en_p_q;
  end

  // R1
  rise_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> ck_p_q);
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              en_fall,
  input  logic              en_rise,
  input  logic              en_low,
  input  logic              dat_s,
  output logic [LONG_W-1:0] act_word,
  output logic              long_word,
  output logic              loaded,
  output logic              upd
);
  logic [LONG_W-1:0] sh_q, sh_d, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              long_d, loaded_d, upd_d;

  always_comb begin
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    act_d    = act_word;
    long_d   = long_word;
    loaded_d = loaded;
    upd_d    = 1'b0;
    if (en_fall) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (sclk_rise && en_low) begin
      sh_d = {sh_q[LONG_W-2:0], dat_s};
      if (cnt_q != CNT_W'(LONG_W)) cnt_d = cnt_q + 1'b1;
    end
    if (en_rise) begin
      upd_d    = 1'b1;
      loaded_d = 1'b1;
      long_d   = (cnt_q == CNT_W'(LONG_W));
      act_d    = long_d ? sh_q : {{PFX_W{1'b0}}, sh_q[SHORT_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      act_word  <= '0;
      long_word <= 1'b0;
      loaded    <= 1'b0;
      upd       <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      cnt_q     <= cnt_d;
      act_word  <= act_d;
      long_word <= long_d;
      loaded    <= loaded_d;
      upd       <= upd_d;
    end
  end

  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LONG_W));
  // R2
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(act_word));
endmodule

// File: rtl/cfg3w_decode.sv
module cfg3w_decode
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LONG_W-1:0] word,
  input  logic              long_word,
  input  logic              loaded,
  output logic [2:0]        mode,
  output logic [1:0]        ramp_lvl,
  output logic [7:0]        dev_pct,
  output logic              ref_hi,
  output logic [6:0]        main_div,
  output logic [4:0]        swallow
);
  mode_e m;

  always_comb begin
    if (!loaded)
      m = MODE_IDLE;
    else if (long_word && word[LONG_W-1:SHORT_W] == CR_PREFIX && word[15:14] == 2'b00)
      m = MODE_RXCR;
    else if (word[15:14] == 2'b01)
      m = word[8] ? MODE_TX : MODE_RX;
    else
      m = MODE_BAD;
    mode     = m;
    ramp_lvl = word[13:12];
    dev_pct  = 8'(DEV_BASE) + 8'({5'b0, word[11:9]} * DEV_STEP);
    ref_hi   = word[7];
    main_div = 7'(DIV_BASE) + {5'b0, word[6:5]};
    swallow  = word[4:0];
  end

  // R6
  dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_pct >= 8'd60 && dev_pct <= 8'd130);
  // R5
  cr_needs_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> long_word);
endmodule

// File: rtl/cfg3w_slave.sv
module cfg3w_slave
  import cfg3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_en_n,
  output logic        upd,
  output logic        long_word,
  output logic [24:0] act_word,
  output logic [2:0]  mode,
  output logic [1:0]  ramp_lvl,
  output logic [7:0]  dev_pct,
  output logic        ref_hi,
  output logic [6:0]  main_div,
  output logic [4:0]  swallow
);
  logic sclk_rise, en_fall, en_rise, en_low, dat_s, loaded;

  cfg3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .sclk_rise(sclk_rise), .en_fall(en_fall),
    .en_rise(en_rise), .en_low(en_low), .dat_s(dat_s));

  cfg3w_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .en_fall(en_fall),
    .en_rise(en_rise), .en_low(en_low), .dat_s(dat_s), .act_word(act_word),
    .long_word(long_word), .loaded(loaded), .upd(upd));

  cfg3w_decode u_dec (
    .clk(clk), .rst_n(rst_n), .word(act_word), .long_word(long_word),
    .loaded(loaded), .mode(mode), .ramp_lvl(ramp_lvl), .dev_pct(dev_pct),
    .ref_hi(ref_hi), .main_div(main_div), .swallow(swallow));

  // R8
  idle_until_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !upd) |=> (mode == 3'd0 || upd));
endmodule

// File: tb/cfg3w_slave_tb.sv
module cfg3w_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic upd, long_word, ref_hi;
  logic [24:0] act_word;
  logic [2:0] mode;
  logic [1:0] ramp_lvl;
  logic [7:0] dev_pct;
  logic [6:0] main_div;
  logic [4:0] swallow;

  int checks = 0, failures = 0, cyc = 0;
  bit chk_on = 1'b0;
  logic [24:0] e_word = '0;
  logic e_long = 1'b0, e_upd = 1'b0;
  int e_mode = 0;

  always #5 clk = ~clk;

  cfg3w_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .upd(upd), .long_word(long_word), .act_word(act_word),
    .mode(mode), .ramp_lvl(ramp_lvl), .dev_pct(dev_pct), .ref_hi(ref_hi),
    .main_div(main_div), .swallow(swallow));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model compared on every clock, shortly after the edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    #2;
    if (chk_on) begin
      chk("R2 R9 upd", int'(upd), int'(e_upd));
      chk("R3 word", int'(act_word), int'(e_word));
      chk("R4 long", int'(long_word), int'(e_long));
      chk("R5 mode", int'(mode), e_mode);
      chk("R6 ramp", int'(ramp_lvl), int'(e_word[13:12]));
      chk("R6 dev", int'(dev_pct), 60 + 10 * int'(e_word[11:9]));
      chk("R7 ref", int'(ref_hi), int'(e_word[7]));
      chk("R7 div", int'(main_div), 86 + int'(e_word[6:5]));
      chk("R7 swallow", int'(swallow), int'(e_word[4:0]));
    end
  end

  task automatic predict(input logic [39:0] w, input int n);
    int k;
    logic [24:0] v;
    k = (n > 25) ? 25 : n;
    v = '0;
    for (int i = 0; i < k; i++) v[i] = w[i];
    if (k < 25) v[24:16] = '0;
    e_word = v;
    e_long = (k == 25);
    if (e_long && v[24:16] == 9'b101000000 && v[15:14] == 2'b00) e_mode = 3;
    else if (v[15:14] == 2'b01) e_mode = v[8] ? 1 : 2;
    else e_mode = 4;
  endtask

  // R1: n bits MSB first, serial clock period of ten system clocks
  task automatic ser_write(input logic [39:0] w, input int n);
    @(negedge clk) ser_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i];
      repeat (5) @(negedge clk);
      ser_clk = 1'b1;
      repeat (5) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk);
    ser_en_n = 1'b1;
    repeat (2) @(negedge clk);
    predict(w, n);
    e_upd = 1'b1;
    @(negedge clk) e_upd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // R1: clocks with select high must leave every output unchanged
  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = i[0];
      repeat (5) @(negedge clk) ser_clk = 1'b1;
      repeat (5) @(negedge clk) ser_clk = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state while held
    chk("R8 rst word", int'(act_word), 0);
    chk("R8 rst mode", int'(mode), 0);
    chk("R8 rst upd", int'(upd), 0);
    chk("R8 rst dev", int'(dev_pct), 60);
    chk("R8 rst div", int'(main_div), 86);
    rst_n = 1'b1;
    chk_on = 1'b1;
    idle_clocks(6);                       // R1 ignored, mode stays idle (R8)
    ser_write(40'h7B5C, 16);              // R5 transmit
    idle_clocks(20);                      // R1 ignored
    ser_write(40'h40FF, 16);              // R5 receive
    ser_write({15'h0, 9'b101000000, 16'h00A5}, 25); // R5 clock recovery
    ser_write({10'h0, 5'b10111, 9'b101000000, 16'h00A5}, 30); // R3 extra bits
    ser_write({20'h0, 4'hF, 16'h7B5C}, 20);  // R3 extra bits, short word
    ser_write({15'h0, 9'h1FF, 16'h00A5}, 25); // R5 long, wrong prefix
    ser_write(40'hC3, 8);                 // R3 zero fill
    ser_write(40'h0, 0);                  // R4 empty transfer
    ser_write(40'hB123, 16);              // R5 bits 15:14 = 10
    for (int k = 0; k < 8; k++)           // R6 R7 code sweep
      ser_write(40'h4100 | 40'(k << 9) | 40'((k % 4) << 5) | 40'(k), 16);
    chk_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule